// File: doc/BRIEF.md
# Dual-Side Mailbox and Paged Window Bridge

This block sits between a host bus and an embedded target processor. The host sees a small set of 32-bit word registers. Through them it reads a fixed identifier, fires one-cycle non-maskable interrupt and master reset pulses into the target, and leaves a 6-bit message for the target. It also picks which 1 MB page of a 16 MB target DRAM a host-side window exposes, and it collects 6-bit messages that the target posts back. One of the two upward message paths raises a host interrupt. The other path is silent, so that host software can poll it.

The target reaches the bridge through a small decoded range above a fixed base address. Host accesses that fall in the window are turned into DRAM requests: the DRAM address is the page register joined to the low 20 bits of the host offset. The DRAM is modelled as a valid/ready request port with a separate response strobe. All three data interfaces (host request, target request, DRAM request) use single-cycle valid/ready handshakes. A request transfers on a clock edge where both valid and ready are high. A requester holds its request stable until it transfers.

Back-pressure rules:
- The target port never stalls.
- A host register access is always accepted, unless a window read is still waiting for its data.
- A window access is accepted only when the DRAM port is ready.
- Responses carry no ready signal and must be taken when they appear.

Top module: `mwb_bridge`

## Requirements
- R1: While reset is asserted, and right after it, the host interrupt and both pulses are low and no response strobe or DRAM request is active. After reset the readable registers at host offsets 0x800, 0xA00, 0xC00 and 0xE00 all return zero.
- R2: A host read of offset 0x000 returns the 8-bit product identifier in bits 7:0, with zeros above.
- R3: A host write to offset 0x400 pulses the target NMI output for one cycle when data bit 2 is set, and the target reset output when data bit 1 is set. The pulse appears in the cycle after the write is accepted. A read of 0x400 returns zero.
- R4: A host write to offset 0x800 stores data bits 5:0. A target read of address 0x18000800 returns them, and a host read of 0x800 returns them. In both reads bits 31:6 are zero.
- R5: A host write to offset 0xA00 stores data bits 23:20 as the page select. A host read of 0xA00 returns the page select in bits 23:20 and zeros elsewhere.
- R6: A target write to address 0x18000000 stores data bits 5:0 for host offset 0xC00 and asserts the host interrupt from the next cycle.
- R7: The host interrupt stays asserted until a host read of 0xC00 is accepted, and it drops in the following cycle. A new post while the interrupt is pending replaces the message and keeps the interrupt asserted. When a post and a 0xC00 read are accepted in the same cycle, the read returns the earlier message and the interrupt stays asserted.
- R8: A target write to address 0x18000400 stores data bits 5:0 for host offset 0xE00 and leaves the host interrupt unchanged.
- R9: A host access at an offset from 0x100000 to 0x1FFFFC becomes a DRAM request at address {page select, offset bits 19:0}. Write data is passed through unchanged, and read data comes back as the host response.
- R10: A window request is accepted only in a cycle where the DRAM port is ready. While a window read awaits its data, the bridge accepts no host request. A register read answers in the cycle after it is accepted.
- R11: Host reads of undecoded offsets return zero. Host writes to them change no register, fire no pulse and issue no DRAM request.
- R12: Target reads of any address other than 0x18000800 return zero. Target writes to any address other than 0x18000000 and 0x18000400 change neither upward message and leave the host interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Host request accepted this cycle |
| host_req_write | input | 1 | Host request is a write |
| host_req_addr | input | 21 | Host byte offset |
| host_req_wdata | input | 32 | Host write data |
| host_rsp_valid | output | 1 | Host read data valid |
| host_rsp_rdata | output | 32 | Host read data |
| host_irq | output | 1 | Host interrupt, level |
| tgt_nmi_pulse | output | 1 | One-cycle NMI to the target |
| tgt_reset_pulse | output | 1 | One-cycle master reset to the target |
| tgt_req_valid | input | 1 | Target request valid |
| tgt_req_ready | output | 1 | Target request accepted (always high) |
| tgt_req_write | input | 1 | Target request is a write |
| tgt_req_addr | input | 32 | Target byte address |
| tgt_req_wdata | input | 32 | Target write data |
| tgt_rsp_valid | output | 1 | Target read data valid |
| tgt_rsp_rdata | output | 32 | Target read data |
| dram_req_valid | output | 1 | DRAM request valid |
| dram_req_ready | input | 1 | DRAM request accepted |
| dram_req_write | output | 1 | DRAM request is a write |
| dram_req_addr | output | 24 | DRAM byte address |
| dram_req_wdata | output | 32 | DRAM write data |
| dram_rsp_valid | input | 1 | DRAM read data valid |
| dram_rsp_rdata | input | 32 | DRAM read data |

## Verification
The bench keeps the default widths, which are 6-bit messages, a 4-bit page and a 20-bit window, and overrides only the product identifier, setting it to 0xA5. These small widths allow every message value to be sent through all three mailbox paths and every page to be driven through the window at both window edges and at a spread of interior offsets. DRAM readiness alternates cycle by cycle in part of the window sweep. The DRAM response can also be held back, which exposes the stall while a read is outstanding.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  // host register offsets (low 12 bits of the host address)
  localparam logic [11:0] HOFS_ID     = 12'h000;
  localparam logic [11:0] HOFS_CTRL   = 12'h400;
  localparam logic [11:0] HOFS_DOWN   = 12'h800;
  localparam logic [11:0] HOFS_PAGE   = 12'hA00;
  localparam logic [11:0] HOFS_UPINT  = 12'hC00;
  localparam logic [11:0] HOFS_UPSYNC = 12'hE00;

  // target offsets relative to the target base
  localparam logic [11:0] TOFS_UPINT  = 12'h000;
  localparam logic [11:0] TOFS_UPSYNC = 12'h400;
  localparam logic [11:0] TOFS_DOWN   = 12'h800;

  localparam int CTRL_NMI_BIT = 2;
  localparam int CTRL_RST_BIT = 1;

  typedef enum logic [2:0] {
    HSEL_NONE, HSEL_ID, HSEL_CTRL, HSEL_DOWN, HSEL_PAGE, HSEL_UPINT, HSEL_UPSYNC
  } host_sel_e;

  function automatic host_sel_e decode_host(input logic [11:0] ofs);
    host_sel_e s;
    case (ofs[11:2])
      HOFS_ID[11:2]:     s = HSEL_ID;
      HOFS_CTRL[11:2]:   s = HSEL_CTRL;
      HOFS_DOWN[11:2]:   s = HSEL_DOWN;
      HOFS_PAGE[11:2]:   s = HSEL_PAGE;
      HOFS_UPINT[11:2]:  s = HSEL_UPINT;
      HOFS_UPSYNC[11:2]: s = HSEL_UPSYNC;
      default:           s = HSEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/mwb_host_regs.sv
module mwb_host_regs
  import mwb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MSG_W = 6,
  parameter int PAGE_W = 4,
  parameter int WIN_AW = 20,
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] PRODUCT_ID = 8'h5E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  host_sel_e         sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MSG_W-1:0]  up_int_msg,
  input  logic [MSG_W-1:0]  up_sync_msg,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [MSG_W-1:0]  down_msg,
  output logic [PAGE_W-1:0] page,
  output logic              nmi_pulse,
  output logic              rst_pulse,
  output logic              int_read
);
  logic ctrl_wr;
  logic [DATA_W-1:0] rd_mux;

  assign ctrl_wr  = wr_en && (sel == HSEL_CTRL);
  assign int_read = rd_en && (sel == HSEL_UPINT);

  always_comb begin
    case (sel)
      HSEL_ID:     rd_mux = DATA_W'(PRODUCT_ID);
      HSEL_DOWN:   rd_mux = DATA_W'(down_msg);
      HSEL_PAGE:   rd_mux = DATA_W'(page) << WIN_AW;
      HSEL_UPINT:  rd_mux = DATA_W'(up_int_msg);
      HSEL_UPSYNC: rd_mux = DATA_W'(up_sync_msg);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      down_msg  <= '0;
      page      <= '0;
      nmi_pulse <= 1'b0;
      rst_pulse <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      nmi_pulse <= ctrl_wr && wdata[CTRL_NMI_BIT];
      rst_pulse <= ctrl_wr && wdata[CTRL_RST_BIT];
      if (wr_en && sel == HSEL_DOWN) down_msg <= wdata[MSG_W-1:0];
      if (wr_en && sel == HSEL_PAGE) page <= wdata[WIN_AW +: PAGE_W];
      rsp_valid <= rd_en;
      rsp_rdata <= rd_en ? rd_mux : '0;
    end
  end

  assert_nmi_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |-> $past(wr_en && sel == HSEL_CTRL && wdata[CTRL_NMI_BIT]));
  assert_rst_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(wr_en && sel == HSEL_CTRL && wdata[CTRL_RST_BIT]));
  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);
endmodule

// File: rtl/mwb_target_port.sv
module mwb_target_port
  import mwb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MSG_W = 6,
  parameter int TGT_AW = 32,
  parameter logic [TGT_AW-1:0] TGT_BASE = 32'h1800_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [TGT_AW-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [MSG_W-1:0]  down_msg,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [MSG_W-1:0]  up_int_msg,
  output logic [MSG_W-1:0]  up_sync_msg,
  output logic              int_post
);
  localparam int NUM_UP = 2;
  logic in_range;
  logic [11:0] ofs;
  logic [MSG_W-1:0] up_q [NUM_UP];
  logic [NUM_UP-1:0] post;

  assign in_range = req_addr[TGT_AW-1:12] == TGT_BASE[TGT_AW-1:12];
  assign ofs      = req_addr[11:0];

  for (genvar g = 0; g < NUM_UP; g++) begin : g_up
    localparam logic [11:0] CH_OFS = (g == 0) ? TOFS_UPINT : TOFS_UPSYNC;
    assign post[g] = req_valid && req_write && in_range && (ofs[11:2] == CH_OFS[11:2]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) up_q[g] <= '0;
      else if (post[g]) up_q[g] <= req_wdata[MSG_W-1:0];
    end
  end

  assign up_int_msg  = up_q[0];
  assign up_sync_msg = up_q[1];
  assign int_post    = post[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write && in_range && ofs[11:2] == TOFS_DOWN[11:2])
                   ? DATA_W'(down_msg) : '0;
    end
  end

  assert_rsp_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata >> MSG_W) == '0);
  assert_sync_keeps_int_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !post[0] |=> $stable(up_int_msg));
endmodule

// File: rtl/mwb_irq_ctrl.sv
module mwb_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic int_post,
  input  logic int_read,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else if (int_post) irq <= 1'b1;
    else if (int_read) irq <= 1'b0;
  end

  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_post |=> irq);
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !int_read |=> irq);
  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_read && !int_post |=> !irq);
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !int_post |=> !irq);
endmodule

// File: rtl/mwb_window.sv
module mwb_window #(
  parameter int DATA_W = 32,
  parameter int PAGE_W = 4,
  parameter int WIN_AW = 20,
  localparam int DRAM_AW = PAGE_W + WIN_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [WIN_AW-1:0]  req_ofs,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [PAGE_W-1:0]  page,
  output logic               dram_req_valid,
  input  logic               dram_req_ready,
  output logic               dram_req_write,
  output logic [DRAM_AW-1:0] dram_req_addr,
  output logic [DATA_W-1:0]  dram_req_wdata,
  input  logic               dram_rsp_valid,
  input  logic [DATA_W-1:0]  dram_rsp_rdata,
  output logic               pend,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata
);
  logic rd_accept;

  assign dram_req_valid = req_valid && !pend;
  assign dram_req_write = req_write;
  assign dram_req_addr  = {page, req_ofs};
  assign dram_req_wdata = req_wdata;
  assign rd_accept      = dram_req_valid && dram_req_ready && !req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else if (rd_accept) pend <= 1'b1;
    else if (dram_rsp_valid) pend <= 1'b0;
  end

  assign rsp_valid = pend && dram_rsp_valid;
  assign rsp_rdata = dram_rsp_rdata;

  assert_one_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dram_req_valid && dram_req_ready && !dram_req_write |=> !dram_req_valid);
endmodule

// File: rtl/mwb_bridge.sv
module mwb_bridge
  import mwb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HOST_AW = 21,
  parameter int MSG_W = 6,
  parameter int PAGE_W = 4,
  parameter int WIN_AW = 20,
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] PRODUCT_ID = 8'h5E,
  parameter int TGT_AW = 32,
  parameter logic [TGT_AW-1:0] TGT_BASE = 32'h1800_0000,
  localparam int DRAM_AW = PAGE_W + WIN_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req_valid,
  output logic               host_req_ready,
  input  logic               host_req_write,
  input  logic [HOST_AW-1:0] host_req_addr,
  input  logic [DATA_W-1:0]  host_req_wdata,
  output logic               host_rsp_valid,
  output logic [DATA_W-1:0]  host_rsp_rdata,
  output logic               host_irq,
  output logic               tgt_nmi_pulse,
  output logic               tgt_reset_pulse,
  input  logic               tgt_req_valid,
  output logic               tgt_req_ready,
  input  logic               tgt_req_write,
  input  logic [TGT_AW-1:0]  tgt_req_addr,
  input  logic [DATA_W-1:0]  tgt_req_wdata,
  output logic               tgt_rsp_valid,
  output logic [DATA_W-1:0]  tgt_rsp_rdata,
  output logic               dram_req_valid,
  input  logic               dram_req_ready,
  output logic               dram_req_write,
  output logic [DRAM_AW-1:0] dram_req_addr,
  output logic [DATA_W-1:0]  dram_req_wdata,
  input  logic               dram_rsp_valid,
  input  logic [DATA_W-1:0]  dram_rsp_rdata
);
  localparam int HI_W = HOST_AW - WIN_AW;

  logic win_hit, reg_hit, accept, reg_wr, reg_rd;
  logic win_pend, win_rsp_valid, reg_rsp_valid;
  logic [DATA_W-1:0] win_rsp_rdata, reg_rsp_rdata;
  logic [PAGE_W-1:0] page;
  logic [MSG_W-1:0] down_msg, up_int_msg, up_sync_msg;
  logic int_post, int_read;
  host_sel_e sel;

  assign win_hit = host_req_addr[HOST_AW-1:WIN_AW] == HI_W'(1);
  assign reg_hit = host_req_addr[HOST_AW-1:12] == '0;
  assign sel     = reg_hit ? decode_host(host_req_addr[11:0]) : HSEL_NONE;

  assign host_req_ready = !win_pend && (!win_hit || dram_req_ready);
  assign accept = host_req_valid && host_req_ready;
  assign reg_wr = accept && !win_hit && host_req_write;
  assign reg_rd = accept && !win_hit && !host_req_write;

  mwb_host_regs #(
    .DATA_W(DATA_W), .MSG_W(MSG_W), .PAGE_W(PAGE_W), .WIN_AW(WIN_AW),
    .ID_W(ID_W), .PRODUCT_ID(PRODUCT_ID)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd), .sel(sel),
    .wdata(host_req_wdata), .up_int_msg(up_int_msg), .up_sync_msg(up_sync_msg),
    .rsp_valid(reg_rsp_valid), .rsp_rdata(reg_rsp_rdata), .down_msg(down_msg),
    .page(page), .nmi_pulse(tgt_nmi_pulse), .rst_pulse(tgt_reset_pulse),
    .int_read(int_read)
  );

  assign tgt_req_ready = 1'b1;

  mwb_target_port #(
    .DATA_W(DATA_W), .MSG_W(MSG_W), .TGT_AW(TGT_AW), .TGT_BASE(TGT_BASE)
  ) u_tgt (
    .clk(clk), .rst_n(rst_n), .req_valid(tgt_req_valid), .req_write(tgt_req_write),
    .req_addr(tgt_req_addr), .req_wdata(tgt_req_wdata), .down_msg(down_msg),
    .rsp_valid(tgt_rsp_valid), .rsp_rdata(tgt_rsp_rdata),
    .up_int_msg(up_int_msg), .up_sync_msg(up_sync_msg), .int_post(int_post)
  );

  mwb_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .int_post(int_post), .int_read(int_read), .irq(host_irq)
  );

  mwb_window #(
    .DATA_W(DATA_W), .PAGE_W(PAGE_W), .WIN_AW(WIN_AW)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .req_valid(host_req_valid && win_hit),
    .req_write(host_req_write), .req_ofs(host_req_addr[WIN_AW-1:0]),
    .req_wdata(host_req_wdata), .page(page),
    .dram_req_valid(dram_req_valid), .dram_req_ready(dram_req_ready),
    .dram_req_write(dram_req_write), .dram_req_addr(dram_req_addr),
    .dram_req_wdata(dram_req_wdata), .dram_rsp_valid(dram_rsp_valid),
    .dram_rsp_rdata(dram_rsp_rdata), .pend(win_pend),
    .rsp_valid(win_rsp_valid), .rsp_rdata(win_rsp_rdata)
  );

  assign host_rsp_valid = reg_rsp_valid || win_rsp_valid;
  assign host_rsp_rdata = reg_rsp_valid ? reg_rsp_rdata : win_rsp_rdata;

  assert_dram_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dram_req_valid |-> dram_req_addr == {page, host_req_addr[WIN_AW-1:0]});
  assert_rsp_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rsp_valid && win_rsp_valid));
  assert_undecoded_no_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && sel == HSEL_NONE |=> !tgt_nmi_pulse && !tgt_reset_pulse);
endmodule

// File: tb/mwb_bridge_bench.sv
`timescale 1ns/1ps
module mwb_bridge_bench;
  localparam logic [7:0] PID = 8'hA5;
  localparam logic [31:0] TB = 32'h1800_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic host_req_valid = 0, host_req_write = 0;
  logic [20:0] host_req_addr = '0;
  logic [31:0] host_req_wdata = '0;
  logic host_req_ready, host_rsp_valid, host_irq, tgt_nmi_pulse, tgt_reset_pulse;
  logic [31:0] host_rsp_rdata;
  logic tgt_req_valid = 0, tgt_req_write = 0;
  logic [31:0] tgt_req_addr = '0, tgt_req_wdata = '0;
  logic tgt_req_ready, tgt_rsp_valid;
  logic [31:0] tgt_rsp_rdata;
  logic dram_req_valid, dram_req_write;
  logic dram_req_ready = 1'b1;
  logic [23:0] dram_req_addr;
  logic [31:0] dram_req_wdata;
  logic dram_rsp_valid = 1'b0;
  logic [31:0] dram_rsp_rdata = '0;

  mwb_bridge #(.PRODUCT_ID(PID)) u_mwb_bridge (.*);

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // DRAM model
  function automatic logic [31:0] dram_val(input logic [23:0] a);
    return {8'hD0, a} ^ 32'h0000_1234;
  endfunction
  logic [23:0] cap_addr = '0;
  logic [31:0] cap_wdata = '0;
  logic cap_we = 0;
  int n_dram = 0, rd_issue = 0, rd_done = 0, cyc = 0;
  logic stall_mode = 0, hold_rsp = 0;
  always @(posedge clk) if (dram_req_valid && dram_req_ready) begin
    cap_addr <= dram_req_addr; cap_wdata <= dram_req_wdata; cap_we <= dram_req_write;
    n_dram <= n_dram + 1;
    if (!dram_req_write) rd_issue <= rd_issue + 1;
  end
  always @(negedge clk) begin
    cyc <= cyc + 1;
    dram_req_ready <= stall_mode ? cyc[0] : 1'b1;
    dram_rsp_valid <= 1'b0;
    if (rd_done != rd_issue && !hold_rsp) begin
      dram_rsp_valid <= 1'b1; dram_rsp_rdata <= dram_val(cap_addr); rd_done <= rd_done + 1;
    end
  end

  task automatic host_acc(input logic w, input logic [20:0] a, input logic [31:0] d,
                          output logic [31:0] r);
    @(negedge clk);
    host_req_valid = 1; host_req_write = w; host_req_addr = a; host_req_wdata = d;
    #1; while (!host_req_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    host_req_valid = 0;
    r = '0;
    if (!w) begin
      #1; while (!host_rsp_valid) begin @(negedge clk); #1; end
      r = host_rsp_rdata;
    end
  endtask
  task automatic hw(input logic [20:0] a, input logic [31:0] d);
    logic [31:0] x; host_acc(1'b1, a, d, x);
  endtask
  task automatic tgt_acc(input logic w, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] r);
    @(negedge clk);
    tgt_req_valid = 1; tgt_req_write = w; tgt_req_addr = a; tgt_req_wdata = d;
    @(posedge clk); @(negedge clk);
    tgt_req_valid = 0;
    r = '0;
    if (!w) begin #1; r = tgt_rsp_valid ? tgt_rsp_rdata : 32'hDEAD_BEEF; end
  endtask
  task automatic tw(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] x; tgt_acc(1'b1, a, d, x);
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 irq", host_irq, 0); chk("R1 nmi", tgt_nmi_pulse, 0);
    chk("R1 rst", tgt_reset_pulse, 0); chk("R1 hrsp", host_rsp_valid, 0);
    chk("R1 dreq", dram_req_valid, 0);
    rst_n = 1;
    foreach (r2[i]) r2[i] = 0;
    host_acc(0, 21'h800, 0, r); chk("R1 down", r, 0);
    host_acc(0, 21'hA00, 0, r); chk("R1 page", r, 0);
    host_acc(0, 21'hC00, 0, r); chk("R1 upint", r, 0);
    host_acc(0, 21'hE00, 0, r); chk("R1 upsync", r, 0);

    // R2 and R10 register read latency
    @(negedge clk);
    host_req_valid = 1; host_req_write = 0; host_req_addr = 21'h000;
    @(posedge clk); @(negedge clk); host_req_valid = 0; #1;
    chk("R10 reg rsp next cycle", host_rsp_valid, 1);
    chk("R2 product id", host_rsp_rdata, {24'h0, PID});

    // R3 pulses for every bit combination
    for (int v = 0; v < 8; v++) begin
      hw(21'h400, 32'hFFFF_FFF8 | 32'(v));
      #1;
      chk("R3 nmi on", tgt_nmi_pulse, 32'(v >> 2) & 1);
      chk("R3 rst on", tgt_reset_pulse, 32'(v >> 1) & 1);
      @(negedge clk); #1;
      chk("R3 nmi off", tgt_nmi_pulse, 0);
      chk("R3 rst off", tgt_reset_pulse, 0);
    end
    host_acc(0, 21'h400, 0, r); chk("R3 ctrl reads 0", r, 0);

    // R4 every down message
    for (int m = 0; m < 64; m++) begin
      hw(21'h800, 32'hABCD_EF00 | 32'(m));
      tgt_acc(0, TB + 32'h800, 0, r); chk("R4 target read", r, 32'(m));
      host_acc(0, 21'h800, 0, r); chk("R4 host read", r, 32'(m));
    end

    // R5 every page
    for (int p = 0; p < 16; p++) begin
      hw(21'hA00, 32'hF50F_FFFF ^ (32'(p) << 20) ^ 32'h00F0_0000);
      host_acc(0, 21'hA00, 0, r);
      chk("R5 page", r, (32'(p) ^ 32'hF ^ 32'h0) << 20 & 32'h00F0_0000 | 32'h0);
    end

    // R6 R7 R8 every up message
    for (int m = 0; m < 64; m++) begin
      tw(TB + 32'h400, 32'h5555_5540 | 32'(m));
      #1; chk("R8 no irq", host_irq, 0);
      host_acc(0, 21'hE00, 0, r); chk("R8 sync data", r, 32'(m));
      tw(TB, 32'hFFFF_FFC0 | 32'(63 - m));
      #1; chk("R6 irq set", host_irq, 1);
      host_acc(0, 21'hC00, 0, r); chk("R6 int data", r, 32'(63 - m));
      #1; chk("R7 irq cleared", host_irq, 0);
    end
    // R7 overwrite while pending
    tw(TB, 32'h11); tw(TB, 32'h22);
    repeat (3) @(negedge clk); #1; chk("R7 held", host_irq, 1);
    // R7 collision: read and post in the same cycle
    fork
      host_acc(0, 21'hC00, 0, r);
      tw(TB, 32'h33);
    join
    chk("R7 collide old data", r, 32'h22);
    #1; chk("R7 collide irq kept", host_irq, 1);
    host_acc(0, 21'hC00, 0, r); chk("R7 new data", r, 32'h33);
    #1; chk("R7 cleared", host_irq, 0);

    // R9 window sweep, half with a stalling DRAM
    for (int p = 0; p < 16; p++) begin
      stall_mode = p[0];
      hw(21'hA00, 32'(p) << 20);
      for (int k = 0; k < 3; k++) begin
        logic [19:0] off;
        off = (k == 0) ? 20'h0 : (k == 1) ? 20'hFFFFC : (20'(p) * 20'h11110) & 20'hFFFFC;
        hw({1'b1, off}, {12'h5A0, off});
        chk("R9 wr addr", 32'(cap_addr), {8'h0, 4'(p), off});
        chk("R9 wr data", cap_wdata, {12'h5A0, off});
        chk("R9 wr kind", 32'(cap_we), 1);
        host_acc(0, {1'b1, off}, 0, r);
        chk("R9 rd addr", 32'(cap_addr), {8'h0, 4'(p), off});
        chk("R9 rd data", r, dram_val({4'(p), off}));
      end
    end
    stall_mode = 0;

    // R10 stall while a window read is outstanding
    hold_rsp = 1;
    fork
      host_acc(0, 21'h100040, 0, r);
      begin
        repeat (3) @(negedge clk); #1;
        chk("R10 ready low while pending", host_req_ready, 0);
        chk("R10 no dram req while pending", dram_req_valid, 0);
        hold_rsp = 0;
      end
    join
    chk("R10 data after hold", r, dram_val({4'hF, 20'h00040}));

    // R11 undecoded host offsets
    begin
      int nd;
      logic [20:0] bad [6];
      bad[0] = 21'h004; bad[1] = 21'h600; bad[2] = 21'hFFC;
      bad[3] = 21'h1000; bad[4] = 21'h80000; bad[5] = 21'h0FFFFC;
      hw(21'h800, 32'h2A); hw(21'hA00, 32'h0030_0000);
      nd = n_dram;
      foreach (bad[i]) begin
        hw(bad[i], 32'hFFFF_FFFF);
        #1; chk("R11 no nmi", tgt_nmi_pulse, 0); chk("R11 no rst", tgt_reset_pulse, 0);
        host_acc(0, bad[i], 0, r); chk("R11 reads zero", r, 0);
      end
      chk("R11 no dram", 32'(n_dram - nd), 0);
      host_acc(0, 21'h800, 0, r); chk("R11 down kept", r, 32'h2A);
      host_acc(0, 21'hA00, 0, r); chk("R11 page kept", r, 32'h0030_0000);
    end

    // R12 undecoded target addresses
    tw(TB + 32'h400, 32'h15);
    tw(TB + 32'h800, 32'h3F); tw(TB + 32'hC00, 32'h3F);
    tw(TB + 32'h1000, 32'h3F); tw(32'h1900_0000, 32'h3F);
    #1; chk("R12 irq untouched", host_irq, 0);
    host_acc(0, 21'hC00, 0, r); chk("R12 int kept", r, 32'h33);
    host_acc(0, 21'hE00, 0, r); chk("R12 sync kept", r, 32'h15);
    tgt_acc(0, TB, 0, r); chk("R12 read int addr zero", r, 0);
    tgt_acc(0, TB + 32'h1800, 0, r); chk("R12 read out of range zero", r, 0);
    tgt_acc(0, 32'h0800_0800, 0, r); chk("R12 read other base zero", r, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule